// File: doc/BRIEF.md
# Overcurrent Confirmation Window Guard

This block watches the sampled output of a buck channel's current-limit comparator. Each time that bit is high while the channel is enabled, the block ends the drive pulse of the current switching cycle with a one-clock terminate pulse, so the inductor current cannot keep building. The first such event also arms a timer built from a clock-derived switching-cycle tick. If another overcurrent arrives while a delayed confirmation window is open, roughly 8 to 16 switching cycles after the arming event, the block latches a shutdown flag. The flag holds both gates of the channel off.

If the window closes with no new overcurrent, the timer goes back to idle without any trace, and the next overcurrent arms it again. Overcurrents that come before the window opens only truncate the pulse. They neither trip the channel nor restart the timer. The only way to clear the shutdown latch is to drop the channel enable, which is what a disable or a power cycle does. While the enable is low the comparator bit is ignored.

Top module: `oc_window_guard`

## Requirements
- R1: After a synchronous reset, `cut_o` and `trip_o` are both 0.
- R2: A clock edge that sees `oc_smp`=1 while `en`=1 makes `cut_o` 1 for exactly the following cycle. A run of such edges gives a run of cycles with `cut_o`=1.
- R3: While `en`=0, `oc_smp` is ignored. `cut_o` stays 0 and the timer is not armed, so the first overcurrent after enabling only arms the timer.
- R4: Counting edges from the arming edge (k=1 at the next edge), an overcurrent at k ≤ OPEN_CYC·CLK_DIV terminates the pulse but neither trips nor restarts the timer.
- R5: `trip_o` rises only in the cycle after an edge that sees an overcurrent inside the open window, and such an edge always raises it.
- R6: When no overcurrent arrives at any k ≤ CLOSE_CYC·CLK_DIV, the timer returns to idle. The next overcurrent arms a fresh window.
- R7: Once `trip_o` is 1, it stays 1 for as long as `en` stays 1, whatever `oc_smp` does.
- R8: A clock edge with `en`=0 clears `trip_o` and the timer in the following cycle.
- R9: The window is inclusive at OPEN_CYC·CLK_DIV+1 and at CLOSE_CYC·CLK_DIV. It excludes k=OPEN_CYC·CLK_DIV and k=CLOSE_CYC·CLK_DIV+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low clears the shutdown latch |
| oc_smp | input | 1 | Sampled current-limit comparator bit, one sample per clock |
| cut_o | output | 1 | Registered pulse ending the current drive pulse |
| trip_o | output | 1 | Latched overcurrent shutdown; gates held off while high |

## Verification
The in-line assertions check the following on every cycle:
- the terminate pulse follows each enabled sample;
- the pulse is silent while the channel is disabled;
- the latch holds while enabled and clears on disable;
- a trip only arises from an overcurrent seen while the window is live;
- the window never opens early and its cycle count never overruns.

Only the bench scenarios can show the timing:
- exact edges at which the window opens and closes;
- early overcurrents that leave the timer's origin unchanged;
- silent re-arming after an empty window.

The bench shows these by comparing against an edge-counting reference model.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
  // Window timer phases
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,  // nothing armed
    WIN_HOLD = 2'd1,  // armed, window not yet open
    WIN_LIVE = 2'd2   // confirmation window open
  } win_state_t;
endpackage

// File: rtl/ocw_tick.sv
// Switching-cycle time base: one-clock tick every DIV clocks, restartable.
module ocw_tick #(
  parameter int DIV = 167
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R9
endmodule

// File: rtl/ocw_window.sv
// Arm / hold / live window sequencer counting switching-cycle ticks.
module ocw_window
  import ocw_pkg::*;
#(
  parameter int OPEN_CYC  = 8,
  parameter int CLOSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tripped,
  input  logic tick,
  input  logic oc_evt,   // enabled overcurrent sample, not yet tripped
  output logic arm,      // this edge starts a new window
  output logic hit,      // this edge confirms the overcurrent
  output logic live
);
  localparam int TW = $clog2(CLOSE_CYC + 1);
  localparam logic [TW-1:0] OPEN_LAST  = TW'(OPEN_CYC - 1);
  localparam logic [TW-1:0] CLOSE_LAST = TW'(CLOSE_CYC - 1);
  localparam logic [TW-1:0] OPEN_AT    = TW'(OPEN_CYC);
  localparam logic [TW-1:0] CLOSE_AT   = TW'(CLOSE_CYC);

  win_state_t    st_q, st_d;
  logic [TW-1:0] cyc_q, cyc_d;

  assign live = (st_q == WIN_LIVE);
  assign arm  = (st_q == WIN_IDLE) && oc_evt;
  assign hit  = live && oc_evt;

  always_comb begin
    st_d  = st_q;
    cyc_d = cyc_q;
    if (!en || tripped) begin
      st_d  = WIN_IDLE;
      cyc_d = '0;
    end else begin
      unique case (st_q)
        WIN_IDLE: if (oc_evt) begin
          st_d  = WIN_HOLD;
          cyc_d = '0;
        end
        WIN_HOLD: if (tick) begin
          cyc_d = cyc_q + 1'b1;
          if (cyc_q == OPEN_LAST) st_d = WIN_LIVE;
        end
        WIN_LIVE: begin
          if (oc_evt) begin
            st_d  = WIN_IDLE;
            cyc_d = '0;
          end else if (tick) begin
            if (cyc_q == CLOSE_LAST) begin
              st_d  = WIN_IDLE;
              cyc_d = '0;
            end else begin
              cyc_d = cyc_q + 1'b1;
            end
          end
        end
        default: begin
          st_d  = WIN_IDLE;
          cyc_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WIN_IDLE;
      cyc_q <= '0;
    end else begin
      st_q  <= st_d;
      cyc_q <= cyc_d;
    end
  end

  AST_NO_EARLY_OPEN: assert property (@(posedge clk) disable iff (rst)
    live |-> (cyc_q >= OPEN_AT)); // R4
  AST_CYC_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cyc_q < CLOSE_AT); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st_q == WIN_IDLE)); // R8
endmodule

// File: rtl/ocw_trip.sv
// Shutdown latch: set by a confirmed overcurrent, cleared only by disable.
module ocw_trip (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hit,
  output logic trip_q
);
  always_ff @(posedge clk) begin
    if (rst || !en) trip_q <= 1'b0;
    else if (hit)   trip_q <= 1'b1;
  end

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (trip_q && en) |=> trip_q); // R7
  AST_TRIP_CLEARED: assert property (@(posedge clk) disable iff (rst)
    !en |=> !trip_q); // R8
endmodule

// File: rtl/oc_window_guard.sv
// Cycle-by-cycle current limit with delayed-window overcurrent shutdown.
module oc_window_guard #(
  parameter int CLK_DIV   = 167,  // clocks per switching cycle
  parameter int OPEN_CYC  = 8,    // switching cycles before window opens
  parameter int CLOSE_CYC = 16    // switching cycles until window closes
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic oc_smp,
  output logic cut_o,
  output logic trip_o
);
  logic tick, arm, hit, live, oc_evt, cut_q;

  assign oc_evt = en && oc_smp && !trip_o;

  ocw_tick #(.DIV(CLK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (arm || !en),
    .tick(tick)
  );

  ocw_window #(.OPEN_CYC(OPEN_CYC), .CLOSE_CYC(CLOSE_CYC)) u_win (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .tripped(trip_o),
    .tick   (tick),
    .oc_evt (oc_evt),
    .arm    (arm),
    .hit    (hit),
    .live   (live)
  );

  ocw_trip u_trip (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .hit   (hit),
    .trip_q(trip_o)
  );

  always_ff @(posedge clk) begin
    if (rst) cut_q <= 1'b0;
    else     cut_q <= en && oc_smp;
  end
  assign cut_o = cut_q;

  AST_CUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (en && oc_smp) |=> cut_o); // R2
  AST_CUT_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !cut_o); // R3
  AST_TRIP_FROM_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!trip_o && !(live && en && oc_smp)) |=> !trip_o); // R5
  AST_LIVE_OC_TRIPS: assert property (@(posedge clk) disable iff (rst)
    (live && en && oc_smp) |=> trip_o); // R5
endmodule

// File: tb/test_oc_window_guard.sv
module test_oc_window_guard;
  localparam int DIV = 167;
  localparam int OC  = 8;
  localparam int CC  = 16;
  localparam int LO  = OC * DIV;
  localparam int HI  = CC * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic oc  = 1'b0;
  logic cut_o, trip_o;

  int total = 0;
  int bad   = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  oc_window_guard #(.CLK_DIV(DIV), .OPEN_CYC(OC), .CLOSE_CYC(CC)) i_oc_window_guard (
    .clk(clk), .rst(rst), .en(en), .oc_smp(oc), .cut_o(cut_o), .trip_o(trip_o)
  );

  // Behavioural reference: edges elapsed since arming
  bit m_cut = 0, m_trip = 0, m_armed = 0;
  int m_el  = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_cut = 0; m_trip = 0; m_armed = 0; m_el = 0;
    end else begin
      m_cut = en && oc;
      if (!en) begin
        m_trip = 0; m_armed = 0;
      end else if (m_trip) begin
        m_armed = 0;
      end else if (m_armed) begin
        int e;
        e = m_el + 1;
        if (oc && e > LO && e <= HI) begin
          m_trip = 1; m_armed = 0;
        end else if (e >= HI) begin
          m_armed = 0;
        end else begin
          m_el = e;
        end
      end else if (oc) begin
        m_armed = 1; m_el = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (cut_o !== m_cut || trip_o !== m_trip) begin
        bad++;
        $display("FAIL %s model: cut=%0b trip=%0b expected cut=%0b trip=%0b",
                 tag, cut_o, trip_o, m_cut, m_trip);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic hit();
    oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input logic v);
    en = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cut after reset", cut_o, 1'b0);
    check("R1 trip after reset", trip_o, 1'b0);
    rst = 1'b0;
    set_en(1'b1);

    // R2: single sample -> one-cycle terminate pulse; this arms
    tag = "R2";
    hit();
    check("R2 cut pulse", cut_o, 1'b1);
    idle(1);
    check("R2 cut returns low", cut_o, 1'b0);
    // R6: empty window expires silently
    tag = "R6";
    idle(HI + 5);
    check("R6 no trip after empty window", trip_o, 1'b0);

    // R4/R9: early and lower-boundary overcurrents do not trip or restart
    tag = "R4";
    hit();                 // arm
    idle(3); hit();        // k=4
    check("R4 early oc cuts", cut_o, 1'b1);
    check("R4 early oc no trip", trip_o, 1'b0);
    tag = "R9";
    idle(LO - 5); hit();   // k=LO
    check("R9 k=open edge no trip", trip_o, 1'b0);
    tag = "R5";
    hit();                 // k=LO+1, proves no restart
    check("R5 oc in window trips", trip_o, 1'b1);

    // R7: latch holds under oc activity
    tag = "R7";
    for (int i = 0; i < 20; i++) begin
      oc = i[0];
      @(negedge clk);
    end
    oc = 1'b0;
    idle(30);
    check("R7 trip held", trip_o, 1'b1);

    // R8: disable clears
    tag = "R8";
    set_en(1'b0);
    check("R8 trip cleared", trip_o, 1'b0);

    // R3: samples ignored while disabled
    tag = "R3";
    hit();
    check("R3 no cut while disabled", cut_o, 1'b0);
    set_en(1'b1);
    hit();                 // arms fresh (would be k far out if the earlier sample armed)
    idle(LO); hit();       // k=LO+1 of this arm
    check("R3 fresh arm then window trips", trip_o, 1'b1);
    set_en(1'b0);
    set_en(1'b1);
    hit();
    idle(LO - 1); hit();   // if disabled sample had armed, still fine; k=LO
    check("R3 no trip at k=open edge", trip_o, 1'b0);
    set_en(1'b0);
    set_en(1'b1);

    // R9 upper boundary inclusive
    tag = "R9";
    hit();
    idle(HI - 1); hit();   // k=HI
    check("R9 k=close edge trips", trip_o, 1'b1);
    set_en(1'b0);
    set_en(1'b1);

    // R9/R6: just past window re-arms, new window trips
    hit();
    idle(HI); hit();       // k=HI+1 -> re-arm
    check("R9 k=close+1 no trip", trip_o, 1'b0);
    tag = "R6";
    idle(LO); hit();
    check("R6 re-armed window trips", trip_o, 1'b1);
    set_en(1'b0);
    check("R8 cleared again", trip_o, 1'b0);

    // R2: back-to-back samples give back-to-back pulses
    tag = "R2";
    set_en(1'b1);
    oc = 1'b1;
    @(negedge clk);
    check("R2 run first", cut_o, 1'b1);
    @(negedge clk);
    check("R2 run second", cut_o, 1'b1);
    oc = 1'b0;
    @(negedge clk);
    check("R2 run end", cut_o, 1'b0);

    idle(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule